// File: doc/BRIEF.md
# Scanline Timing and Display Status Generator

This block sequences video lines for a display controller. A pixel-clock counter walks each scanline through an active period followed by a horizontal blanking period. A line counter walks the frame through a fixed number of lines, and a fixed line marks the start of vertical blanking. From these two counters it maintains a 16-bit display status word that holds the vblank, hblank and line-compare flags, the three interrupt enables and a 9-bit compare line. It also presents the current line number so it can be read.

On every boundary it crosses, the block emits single-cycle strobes. These are interrupt requests for hblank, vblank and line match, each gated by its enable. They are also start triggers for a DMA engine, issued at hblank, at every line start and at vblank. A bus bridge writes the status halfword to set the enables and the compare line. The flag bits cannot be written. The pixel pipeline, the DMA engine and the bus bridge sit outside this block.

With the default parameters a line is 3072 active clocks plus 1188 blanking clocks. A frame is 263 lines, and vblank begins at line 192.

Top module: `scan_timing_gen`

## Requirements
- R1: A line lasts ACTIVE_CLKS+BLANK_CLKS clocks. Status bit 1 (hblank) becomes 1 on the edge that ends the ACTIVE_CLKS-th clock of the line. It returns to 0 on the edge that starts the next line.
- R2: `line_o` counts 0 to LINES-1 and then wraps to 0. Status bit 0 (vblank) is cleared on the edge where the counter wraps to 0.
- R3: At hblank start, `irq_hblank` pulses when status bit 4 (hblank interrupt enable) is 1.
- R4: `dma_hblank` pulses at hblank start only when `line_o` is below VBLANK_LINE.
- R5: On the edge where `line_o` becomes VBLANK_LINE, several things happen. Status bit 0 is set and `dma_vblank` pulses. `irq_vblank` also pulses if status bit 3 (vblank interrupt enable) is 1.
- R6: `dma_line` pulses on the edge that begins every line. That edge is reached after every ACTIVE_CLKS+BLANK_CLKS clocks from reset release.
- R7: The compare line is {status[7], status[15:8]}. On each line-start edge, status bit 2 is loaded with (new line == compare line), using the compare value held before that edge. `irq_vmatch` pulses when the match is true and status bit 5 is 1.
- R8: A write stores data bits 15:7 and 5:3. Status bits 2:0 cannot be written, and status bit 6 always reads 0. The new enables and compare line take effect from the next edge.
- R9: Every strobe is high for exactly one clock, in the cycle after the edge that crosses its boundary. After reset, all outputs are 0 and the first line starts at line 0 with no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Status halfword write strobe |
| cfg_wdata | input | 16 | Status halfword write data |
| status_o | output | 16 | Display status word |
| line_o | output | 9 | Current line number |
| irq_hblank | output | 1 | Hblank interrupt request pulse |
| irq_vblank | output | 1 | Vblank interrupt request pulse |
| irq_vmatch | output | 1 | Line-compare interrupt request pulse |
| dma_hblank | output | 1 | Hblank DMA start pulse |
| dma_line | output | 1 | Line-start DMA pulse |
| dma_vblank | output | 1 | Vblank DMA start pulse |

## Verification
Every output is a register, so each effect of a counter boundary or a write appears exactly one edge later. The strobes, the flags and `line_o` change on the edge that crosses the boundary. A written enable or compare line is visible in `status_o` after its write edge, but it first affects a strobe or the match flag on the following edge. The bench counts edges since reset release and derives the hblank, line and match expectations from that count. It keeps the configuration that was in effect before each edge apart from the configuration written on it. It samples every output at the falling edge, half a cycle after the edge that caused it.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int LINE_W = 9;

   typedef logic [LINE_W-1:0] line_t;

   typedef struct packed {
      logic  hblank_start;
      logic  line_end;
      line_t next_line;
   } scan_ev_t;
endpackage

// File: rtl/scan_counter.sv
module scan_counter
   import scan_pkg::*;
#(
   parameter int ACTIVE_CLKS = 3072,
   parameter int BLANK_CLKS  = 1188,
   parameter int LINES       = 263
) (
   input  logic     clk,
   input  logic     rst_n,
   output line_t    line,
   output scan_ev_t ev
);
   localparam int LINE_CLKS = ACTIVE_CLKS + BLANK_CLKS;
   localparam int HW        = $clog2(LINE_CLKS);

   logic [HW-1:0] hcnt;
   line_t         vcnt;

   assign ev.hblank_start = (hcnt == HW'(ACTIVE_CLKS - 1));
   assign ev.line_end     = (hcnt == HW'(LINE_CLKS - 1));
   assign ev.next_line    = (vcnt == line_t'(LINES - 1)) ? '0 : vcnt + 1'b1;
   assign line            = vcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (ev.line_end) begin
         hcnt <= '0;
         vcnt <= ev.next_line;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt < HW'(LINE_CLKS)); // R1
   AST_VCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      vcnt < line_t'(LINES)); // R2
endmodule

// File: rtl/scan_status.sv
module scan_status
   import scan_pkg::*;
#(
   parameter int VBLANK_LINE = 192
) (
   input  logic        clk,
   input  logic        rst_n,
   input  line_t       line,
   input  scan_ev_t    ev,
   input  logic        cfg_we,
   input  logic [15:0] cfg_wdata,
   output logic [15:0] status,
   output logic        irq_hb,
   output logic        irq_vb,
   output logic        irq_vm,
   output logic        dma_hb,
   output logic        dma_ln,
   output logic        dma_vb
);
   logic       vbl_q, hbl_q, mat_q;
   logic [2:0] en_q;   // [0] vblank, [1] hblank, [2] match
   line_t      cmp_q;
   logic       hit;

   assign hit    = (ev.next_line == cmp_q);
   assign status = {cmp_q[7:0], cmp_q[8], 1'b0, en_q, mat_q, hbl_q, vbl_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vbl_q  <= 1'b0;
         hbl_q  <= 1'b0;
         mat_q  <= 1'b0;
         en_q   <= '0;
         cmp_q  <= '0;
         irq_hb <= 1'b0;
         irq_vb <= 1'b0;
         irq_vm <= 1'b0;
         dma_hb <= 1'b0;
         dma_ln <= 1'b0;
         dma_vb <= 1'b0;
      end else begin
         irq_hb <= 1'b0;
         irq_vb <= 1'b0;
         irq_vm <= 1'b0;
         dma_hb <= 1'b0;
         dma_ln <= 1'b0;
         dma_vb <= 1'b0;
         if (cfg_we) begin
            cmp_q <= {cfg_wdata[7], cfg_wdata[15:8]};
            en_q  <= cfg_wdata[5:3];
         end
         if (ev.hblank_start) begin
            hbl_q  <= 1'b1;
            irq_hb <= en_q[1];
            dma_hb <= (line < line_t'(VBLANK_LINE));
         end
         if (ev.line_end) begin
            hbl_q  <= 1'b0;
            dma_ln <= 1'b1;
            mat_q  <= hit;
            irq_vm <= hit & en_q[2];
            if (ev.next_line == line_t'(VBLANK_LINE)) begin
               vbl_q  <= 1'b1;
               irq_vb <= en_q[0];
               dma_vb <= 1'b1;
            end else if (ev.next_line == '0) begin
               vbl_q <= 1'b0;
            end
         end
      end
   end

   AST_HB_EV_NOT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.hblank_start && ev.line_end)); // R1
   AST_RO_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (status[6] == 1'b0)); // R8
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
   import scan_pkg::*;
#(
   parameter int ACTIVE_CLKS = 3072,
   parameter int BLANK_CLKS  = 1188,
   parameter int LINES       = 263,
   parameter int VBLANK_LINE = 192
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [15:0] cfg_wdata,
   output logic [15:0] status_o,
   output logic [8:0]  line_o,
   output logic        irq_hblank,
   output logic        irq_vblank,
   output logic        irq_vmatch,
   output logic        dma_hblank,
   output logic        dma_line,
   output logic        dma_vblank
);
   generate
      if (ACTIVE_CLKS < 1 || BLANK_CLKS < 1) begin : g_bad_clks
         $error("scan_timing_gen: both line periods need at least one clock");
      end
      if (LINES < 2 || LINES > (1 << LINE_W)) begin : g_bad_lines
         $error("scan_timing_gen: LINES out of range for the line counter");
      end
      if (VBLANK_LINE < 1 || VBLANK_LINE >= LINES) begin : g_bad_vbl
         $error("scan_timing_gen: VBLANK_LINE must lie inside the frame");
      end
   endgenerate

   line_t    line;
   scan_ev_t ev;

   scan_counter #(
      .ACTIVE_CLKS(ACTIVE_CLKS),
      .BLANK_CLKS (BLANK_CLKS),
      .LINES      (LINES)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .line (line),
      .ev   (ev)
   );

   scan_status #(
      .VBLANK_LINE(VBLANK_LINE)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .line     (line),
      .ev       (ev),
      .cfg_we   (cfg_we),
      .cfg_wdata(cfg_wdata),
      .status   (status_o),
      .irq_hb   (irq_hblank),
      .irq_vb   (irq_vblank),
      .irq_vm   (irq_vmatch),
      .dma_hb   (dma_hblank),
      .dma_ln   (dma_line),
      .dma_vb   (dma_vblank)
   );

   assign line_o = line;

   AST_HB_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_hblank |-> (line_o < line_t'(VBLANK_LINE))); // R4
   AST_VBL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[0]) |-> (line_o == line_t'(VBLANK_LINE))); // R5
   AST_VBL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[0]) |-> (line_o == '0)); // R2
   AST_HB_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hblank |-> (status_o[1] && $past(status_o[4]))); // R3
   AST_LINE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_line |=> !dma_line); // R9
   AST_LINE_HB_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      dma_line |-> !status_o[1]); // R1
   AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dma_line |-> (status_o[2] ==
                    (line_o == $past({status_o[7], status_o[15:8]})))); // R7
endmodule

// File: tb/tb_scan_timing_gen.sv
module tb_scan_timing_gen;
   localparam int A   = 10;
   localparam int B   = 5;
   localparam int L   = A + B;
   localparam int NL  = 16;
   localparam int VBL = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] status_o;
   logic [8:0]  line_o;
   logic        irq_hblank, irq_vblank, irq_vmatch;
   logic        dma_hblank, dma_line, dma_vblank;

   int checks = 0;
   int fails  = 0;

   scan_timing_gen #(.ACTIVE_CLKS(A), .BLANK_CLKS(B), .LINES(NL), .VBLANK_LINE(VBL)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .status_o(status_o), .line_o(line_o),
      .irq_hblank(irq_hblank), .irq_vblank(irq_vblank), .irq_vmatch(irq_vmatch),
      .dma_hblank(dma_hblank), .dma_line(dma_line), .dma_vblank(dma_vblank));

   always #4 clk = ~clk;   // 125 MHz

   // reference model state, from the requirements
   int          n;
   logic [15:0] cfg_eff;
   logic        m_exp;
   logic        e_ihb, e_ivb, e_ivm, e_dhb, e_dln, e_dvb;

   function automatic logic [8:0] cmp_of(input logic [15:0] c);
      return {c[7], c[15:8]};
   endfunction

   function automatic int line_of(input int k);
      return (k / L) % NL;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         n = 0; cfg_eff = '0; m_exp = 1'b0;
         {e_ihb, e_ivb, e_ivm, e_dhb, e_dln, e_dvb} = '0;
      end else begin
         n = n + 1;
         e_ihb = ((n % L) == A) && cfg_eff[4];                 // R3
         e_dhb = ((n % L) == A) && (line_of(n) < VBL);         // R4
         e_dln = ((n % L) == 0);                               // R6
         e_dvb = ((n % L) == 0) && (line_of(n) == VBL);        // R5
         e_ivb = e_dvb && cfg_eff[3];                          // R5
         if ((n % L) == 0) m_exp = (9'(line_of(n)) == cmp_of(cfg_eff)); // R7
         e_ivm = ((n % L) == 0) && m_exp && cfg_eff[5];        // R7
         if (cfg_we) cfg_eff = cfg_wdata;                      // R8
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at edge %0d: actual %0h expected %0h", req, what, n, act, exp);
      end
   endtask

   task automatic check_all();
      logic [15:0] es;
      es = {cfg_eff[15:7], 1'b0, cfg_eff[5:3], m_exp,
            ((n % L) >= A) && (n > 0), line_of(n) >= VBL};
      chk("R1", "hblank flag", 32'(status_o[1]), 32'(es[1]));
      chk("R2", "line_o", 32'(line_o), 32'(line_of(n)));
      chk("R2", "vblank flag", 32'(status_o[0]), 32'(es[0]));
      chk("R7", "match flag", 32'(status_o[2]), 32'(es[2]));
      chk("R8", "status upper", 32'(status_o[15:3]), 32'(es[15:3]));
      chk("R3", "irq_hblank", 32'(irq_hblank), 32'(e_ihb));
      chk("R4", "dma_hblank", 32'(dma_hblank), 32'(e_dhb));
      chk("R5", "irq_vblank", 32'(irq_vblank), 32'(e_ivb));
      chk("R5", "dma_vblank", 32'(dma_vblank), 32'(e_dvb));
      chk("R6", "dma_line", 32'(dma_line), 32'(e_dln));
      chk("R7", "irq_vmatch", 32'(irq_vmatch), 32'(e_ivm));
   endtask

   function automatic logic [15:0] mk_cfg(input logic [8:0] cmp, input logic [6:0] low);
      return {cmp[7:0], cmp[8], low};
   endfunction

   bit timed_out = 1'b0;
   initial begin
      repeat (20000) @(posedge clk);
      timed_out = 1'b1;
   end

   initial begin
      int seed;
      int dummy;
      seed  = 7;
      dummy = $urandom(seed);
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "status at reset", 32'(status_o), 32'h0);
      chk("R9", "line at reset", 32'(line_o), 32'h0);
      chk("R9", "strobes at reset",
          32'({irq_hblank, irq_vblank, irq_vmatch, dma_hblank, dma_line, dma_vblank}), 32'h0);
      rst_n = 1'b1;
      // directed: compare line 0 with all enables, try to set read-only bits (R8, R7 wrap match)
      cfg_we = 1'b1; cfg_wdata = mk_cfg(9'd0, 7'b1111111);
      @(negedge clk); check_all(); cfg_we = 1'b0;
      for (int i = 0; i < 2 * NL * L; i++) begin
         @(negedge clk); check_all();
      end
      // directed: compare on vblank line, bit 8 of compare set (never matches)
      cfg_we = 1'b1; cfg_wdata = mk_cfg(9'd256 + 9'(VBL), 7'b0111000);
      @(negedge clk); check_all(); cfg_we = 1'b0;
      for (int i = 0; i < NL * L; i++) begin
         @(negedge clk); check_all();
      end
      cfg_we = 1'b1; cfg_wdata = mk_cfg(9'(VBL), 7'b0010111);
      @(negedge clk); check_all(); cfg_we = 1'b0;
      for (int i = 0; i < NL * L; i++) begin
         @(negedge clk); check_all();
      end
      // random configuration writes at random times
      for (int i = 0; i < 6000 && !timed_out; i++) begin
         @(negedge clk); check_all();
         if (($urandom % 23) == 0) begin
            cfg_we    = 1'b1;
            cfg_wdata = mk_cfg(9'($urandom % (NL + 3)), 7'($urandom));
         end else begin
            cfg_we = 1'b0;
         end
      end
      if (timed_out) begin
         checks++; fails++;
         $display("FAIL watchdog expired: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule